// File: doc/BRIEF.md
# Serial Fractional Multiplier with Marker Termination

This block multiplies two 30-bit two's-complement words that carry three integer bits (the sign and two magnitude bits) and 27 fraction bits. A word's value is its signed code divided by 2^27. The block records the product sign and replaces each operand by its magnitude. It then forms the 58-bit magnitude product one bit per cycle, using shift-and-add from the least significant multiplier bit upward. At the end it selects the requested part of the product and puts the sign back by complementing.

No bit counter runs the loop. A 1 is loaded into the multiplier register's sign position, which always holds 0 for a magnitude. When that marker reaches bit 0, every multiplier bit has been consumed and the block finishes. A caller pulses `start_i` with the operands and an order code, then waits for the one-cycle `done_o` pulse. The result and overflow flag stay valid until the next completion.

Top module: `frac_serial_mul`

## Requirements
- R1: While `rst_ni` is low and after its release, `done_o`, `result_o` and `ovf_o` are all zero until the first operation completes.
- R2: An operand is a 30-bit two's-complement code with value code/2^27. The code 30'h2000_0000 (most negative) is outside the accepted domain. Magnitudes are |code| as 29-bit unsigned values, and P denotes the 58-bit product of the two magnitudes.
- R3: With `order_i` = 2'b01 (high, truncated), the result magnitude is floor(P / 2^27), limited to its 29 low bits.
- R4: With `order_i[1]` = 1 (codes 2'b10 and 2'b11, high, rounded), the result magnitude is floor((P + 2^26) / 2^27), limited to its 29 low bits.
- R5: With `order_i` = 2'b00 (low order), `result_o` is P[26:0] with bits 29:27 zero. The sign is not applied and `ovf_o` is 0.
- R6: For the high orders, `ovf_o` is 1 exactly when the shifted (and, for R4, rounded) magnitude is 2^29 or more, that is, when the product's absolute value is 4.0 or more.
- R7: For the high orders, the result is the two's complement of the magnitude when exactly one operand is negative. Otherwise it is the magnitude itself. A zero magnitude always gives 0.
- R8: `done_o` is a single-cycle pulse that rises on the 30th rising clock edge after the edge that accepts `start_i`. This timing holds for every operand value.
- R9: A `start_i` pulse that arrives while an operation is in progress is ignored. The running operation completes with its own operands and order, and it produces exactly one `done_o` pulse.
- R10: `result_o` and `ovf_o` change only in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled when idle |
| op_a_i | input | 30 | Multiplicand word |
| op_b_i | input | 30 | Multiplier word |
| order_i | input | 2 | 00 low, 01 high truncated, 1x high rounded |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 30 | Product word in the selected order |
| ovf_o | output | 1 | High-order magnitude of 4.0 or more |

## Verification
The assertions assume that the operands never carry the most negative code in the cycle where `start_i` is accepted. Under that assumption every magnitude fits in 29 bits and the marker position starts clear. The assertions also assume that `order_i` and the operands matter only in that accepting cycle. The stimulus remaps any pseudo-random draw that hits the excluded code, and it changes operands and order only at the falling edge. A start issued mid-run carries different operands and order, so any leakage into the running product becomes visible.

// File: rtl/fsm_mul_pkg.sv
package fsm_mul_pkg;
  localparam int unsigned WORD_W = 30;
  localparam int unsigned INT_W  = 3;
  localparam int unsigned FRAC_W = WORD_W - INT_W;
  localparam int unsigned MAG_W  = WORD_W - 1;
  localparam int unsigned PROD_W = 2 * MAG_W;

  typedef enum logic [1:0] {
    ORD_LOW   = 2'b00,
    ORD_HIGH  = 2'b01,
    ORD_ROUND = 2'b10,
    ORD_RND2  = 2'b11
  } order_e;
endpackage

// File: rtl/fsm_mul_abs.sv
module fsm_mul_abs
  import fsm_mul_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              neg_o,
  output logic [MAG_W-1:0]  mag_o
);
  logic [WORD_W-1:0] cmpl;

  assign cmpl  = WORD_W'(~word_i + 1'b1);
  assign neg_o = word_i[WORD_W-1];
  assign mag_o = neg_o ? cmpl[MAG_W-1:0] : word_i[MAG_W-1:0];
endmodule

// File: rtl/fsm_mul_core.sv
module fsm_mul_core
  import fsm_mul_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [MAG_W-1:0]  mcand_i,
  input  logic [MAG_W-1:0]  mplier_i,
  output logic              last_o,
  output logic [PROD_W-1:0] prod_o
);
  logic [MAG_W-1:0] mcand_q;
  logic [MAG_W:0]   mq_q;   // marker at top, multiplier magnitude below
  logic [MAG_W-1:0] acc_q;
  logic [MAG_W-1:0] plo_q;
  logic [MAG_W:0]   sum;

  assign sum    = {1'b0, acc_q} + (mq_q[0] ? {1'b0, mcand_q} : '0);
  assign last_o = (mq_q == (MAG_W+1)'(1));
  assign prod_o = {acc_q, plo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      mq_q    <= '0;
      acc_q   <= '0;
      plo_q   <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      mq_q    <= {1'b1, mplier_i};
      acc_q   <= '0;
      plo_q   <= '0;
    end else if (step_i) begin
      mq_q    <= mq_q >> 1;
      acc_q   <= sum[MAG_W:1];
      plo_q   <= {sum[0], plo_q[MAG_W-1:1]};
    end
  end

  // marker keeps the multiplier register non-empty for the whole run
  assert_marker_alive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (mq_q != '0));

  // a busy-time start (load) must never disturb the multiplicand
  assert_mcand_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> $stable(mcand_q));
endmodule

// File: rtl/fsm_mul_format.sv
module fsm_mul_format
  import fsm_mul_pkg::*;
(
  input  logic [PROD_W-1:0] prod_i,
  input  logic              neg_i,
  input  logic [1:0]        order_i,
  output logic [WORD_W-1:0] result_o,
  output logic              ovf_o
);
  localparam int unsigned HI_W = PROD_W - FRAC_W + 1;

  logic [PROD_W:0]   rnd;
  logic [HI_W-1:0]   hi;
  logic [WORD_W-1:0] mag_w;
  logic [WORD_W-1:0] hi_res;

  assign rnd    = {1'b0, prod_i} + (order_i[1] ? (PROD_W+1)'(1) << (FRAC_W-1) : '0);
  assign hi     = HI_W'(rnd >> FRAC_W);
  assign mag_w  = {1'b0, hi[MAG_W-1:0]};
  assign hi_res = neg_i ? WORD_W'(~mag_w + 1'b1) : mag_w;

  always_comb begin
    if (order_i == ORD_LOW) begin
      result_o = {{INT_W{1'b0}}, prod_i[FRAC_W-1:0]};
      ovf_o    = 1'b0;
    end else begin
      result_o = hi_res;
      ovf_o    = |hi[HI_W-1:MAG_W];
    end
  end
endmodule

// File: rtl/frac_serial_mul.sv
module frac_serial_mul
  import fsm_mul_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  input  logic [1:0]        order_i,
  output logic              done_o,
  output logic [WORD_W-1:0] result_o,
  output logic              ovf_o
);
  logic [1:0][WORD_W-1:0] ops;
  logic [1:0]             negs;
  logic [1:0][MAG_W-1:0]  mags;

  logic              busy_q, done_q, ovf_q, neg_q, past_ok_q;
  logic [1:0]        order_q;
  logic [WORD_W-1:0] result_q;
  logic              accept, last;
  logic [PROD_W-1:0] prod;
  logic [WORD_W-1:0] fmt_res;
  logic              fmt_ovf;

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_abs
    fsm_mul_abs u_abs (
      .word_i (ops[g]),
      .neg_o  (negs[g]),
      .mag_o  (mags[g])
    );
  end

  assign accept = start_i && !busy_q;

  fsm_mul_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy_q),
    .load_i   (accept),
    .step_i   (busy_q && !last),
    .mcand_i  (mags[0]),
    .mplier_i (mags[1]),
    .last_o   (last),
    .prod_o   (prod)
  );

  fsm_mul_format u_fmt (
    .prod_i   (prod),
    .neg_i    (neg_q),
    .order_i  (order_q),
    .result_o (fmt_res),
    .ovf_o    (fmt_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      ovf_q     <= 1'b0;
      neg_q     <= 1'b0;
      order_q   <= ORD_LOW;
      result_q  <= '0;
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
      done_q    <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        order_q <= order_i;
        neg_q   <= negs[0] ^ negs[1];
      end else if (busy_q && last) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        result_q <= fmt_res;
        ovf_q    <= fmt_ovf;
      end
    end
  end

  assign done_o   = done_q;
  assign result_o = result_q;
  assign ovf_o    = ovf_q;

  assert_operand_domain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (op_a_i != 30'h2000_0000 && op_b_i != 30'h2000_0000));

  assert_low_order_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && order_q == ORD_LOW) |-> (result_o[WORD_W-1:FRAC_W] == '0 && !ovf_o));

  assert_sign_applied_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && order_q != ORD_LOW && !ovf_o && result_o != '0) |-> (result_o[WORD_W-1] == neg_q));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_order_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && past_ok_q) |-> $stable(order_q) && $stable(neg_q));

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !done_o) |-> ($stable(result_o) && $stable(ovf_o)));
endmodule

// File: tb/frac_serial_mul_bench.sv
module frac_serial_mul_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [29:0] op_a_i = '0;
  logic [29:0] op_b_i = '0;
  logic [1:0]  order_i = '0;
  logic        done_o;
  logic [29:0] result_o;
  logic        ovf_o;

  int total = 0;
  int bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  frac_serial_mul u_frac_serial_mul (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_a_i(op_a_i),
    .op_b_i(op_b_i), .order_i(order_i), .done_o(done_o),
    .result_o(result_o), .ovf_o(ovf_o)
  );

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [29:0] neg30(input logic [29:0] v);
    return 30'(~v + 1'b1);
  endfunction

  function automatic void model(input logic [29:0] a, input logic [29:0] b, input logic [1:0] ord,
                                output logic [29:0] r, output logic o);
    logic [63:0] ma, mb, p, h;
    logic [29:0] m;
    ma = a[29] ? 64'(neg30(a)) : 64'(a);
    mb = b[29] ? 64'(neg30(b)) : 64'(b);
    p = ma * mb;
    if (ord == 2'b00) begin
      r = {3'b000, p[26:0]};
      o = 1'b0;
    end else begin
      h = (p + (ord[1] ? (64'd1 << 26) : 64'd0)) >> 27;
      o = (h >= (64'd1 << 29));
      m = {1'b0, h[28:0]};
      r = (a[29] ^ b[29]) ? neg30(m) : m;
    end
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  // run one op; returns latency in edges after the accepting edge
  task automatic run_op(input logic [29:0] a, input logic [29:0] b, input logic [1:0] ord,
                        output int lat);
    @(negedge clk);
    op_a_i = a; op_b_i = b; order_i = ord; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done_o) break;
    end
  endtask

  task automatic do_check(input logic [29:0] a, input logic [29:0] b, input logic [1:0] ord,
                          input string tag);
    logic [29:0] er;
    logic eo;
    int lat;
    model(a, b, ord, er, eo);
    run_op(a, b, ord, lat);
    check(result_o == er, tag, 64'(result_o), 64'(er));
    check(ovf_o == eo, {tag, " ovf R6"}, 64'(ovf_o), 64'(eo));
  endtask

  task automatic t_reset;
    check(done_o == 1'b0 && result_o == '0 && ovf_o == 1'b0, "R1 reset outputs",
          {31'd0, done_o, result_o, ovf_o}, 64'd0);
  endtask

  task automatic t_basic;
    // 1.0 * 1.0 = 1.0, truncated high
    do_check(30'h0800_0000, 30'h0800_0000, 2'b01, "R3 one times one");
    check(result_o == 30'h0800_0000, "R3 value 1.0", 64'(result_o), 64'h0800_0000);
    do_check(30'h0C00_0000, 30'h0A00_0000, 2'b01, "R3 1.5x1.25");
    do_check(30'h0000_0000, 30'h0BCD_1234, 2'b01, "R7 zero operand");
  endtask

  task automatic t_signs;
    do_check(neg30(30'h0800_0000), 30'h0C00_0000, 2'b01, "R7 neg times pos");
    check(result_o == neg30(30'h0C00_0000), "R7 -1.5 value", 64'(result_o), 64'(neg30(30'h0C00_0000)));
    do_check(neg30(30'h0A00_0000), neg30(30'h0600_0000), 2'b01, "R7 neg times neg");
    do_check(30'h0300_0000, neg30(30'h0000_0001), 2'b01, "R7 tiny negative truncates to 0");
    check(result_o == '0, "R7 negative zero is 0", 64'(result_o), 64'd0);
  endtask

  task automatic t_low;
    do_check(30'h0000_0001, 30'h0000_0003, 2'b00, "R5 low order small");
    check(result_o == 30'd3, "R5 low value", 64'(result_o), 64'd3);
    do_check(neg30(30'h0FFF_FFFF), 30'h1234_5678, 2'b00, "R5 low order negative ignored sign");
    check(result_o[29:27] == 3'b000, "R5 top bits zero", 64'(result_o[29:27]), 64'd0);
  endtask

  task automatic t_round;
    // 2^-27 * 0.5: truncated 0, rounded 1 lsb
    do_check(30'h0000_0001, 30'h0400_0000, 2'b01, "R3 half lsb truncated");
    check(result_o == '0, "R3 half lsb drops", 64'(result_o), 64'd0);
    do_check(30'h0000_0001, 30'h0400_0000, 2'b10, "R4 half lsb rounds up");
    check(result_o == 30'd1, "R4 rounded to 1", 64'(result_o), 64'd1);
    do_check(30'h0000_0001, 30'h03FF_FFFF, 2'b11, "R4 below half stays");
    check(result_o == '0, "R4 below half", 64'(result_o), 64'd0);
    do_check(neg30(30'h0000_0003), 30'h0400_0000, 2'b10, "R4 negative rounding");
  endtask

  task automatic t_ovf;
    do_check(30'h1000_0000, 30'h1000_0000, 2'b01, "R6 2.0x2.0 overflows");
    check(ovf_o == 1'b1, "R6 ovf set at 4.0", 64'(ovf_o), 64'd1);
    do_check(30'h1FFF_FFFF, 30'h0800_0000, 2'b01, "R6 just below 4.0");
    check(ovf_o == 1'b0, "R6 no ovf below 4.0", 64'(ovf_o), 64'd0);
    do_check(30'h1FFF_FFFF, 30'h0800_0001, 2'b10, "R6 rounded over 4.0");
    do_check(30'h1FFF_FFFF, 30'h1FFF_FFFF, 2'b00, "R5 low order never ovf");
    check(ovf_o == 1'b0, "R5 ovf clear in low order", 64'(ovf_o), 64'd0);
  endtask

  task automatic t_latency;
    int lat;
    logic prev;
    run_op(30'h1FFF_FFFF, neg30(30'h1FFF_FFFF), 2'b01, lat);
    check(lat == 30, "R8 latency all-ones", 64'(lat), 64'd30);
    run_op(30'h0000_0005, 30'h0000_0000, 2'b10, lat);
    check(lat == 30, "R8 latency zero multiplier", 64'(lat), 64'd30);
    prev = done_o;
    @(posedge clk); @(negedge clk);
    check(prev && !done_o, "R8 single-cycle done", 64'(done_o), 64'd0);
  endtask

  task automatic t_busy;
    logic [29:0] er; logic eo;
    int dones = 0;
    int first = -1;
    logic [29:0] held;
    model(30'h0C00_0000, neg30(30'h0900_0000), 2'b01, er, eo);
    @(negedge clk);
    op_a_i = 30'h0C00_0000; op_b_i = neg30(30'h0900_0000); order_i = 2'b01; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    for (int i = 1; i <= 45; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 5) begin
        op_a_i = 30'h0123_4567; op_b_i = 30'h0765_4321; order_i = 2'b00; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (done_o) begin dones++; if (first < 0) first = i; end
    end
    check(dones == 1, "R9 one done for busy start", 64'(dones), 64'd1);
    check(first == 30, "R9 done at original timing", 64'(first), 64'd30);
    check(result_o == er, "R9 result from first operands", 64'(result_o), 64'(er));
    held = result_o;
    // R10: new operands at inputs without start must not alter outputs
    op_a_i = 30'h1111_1111; op_b_i = 30'h0222_2222; order_i = 2'b10;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(result_o == held && ovf_o == eo, "R10 outputs hold between dones", 64'(result_o), 64'(held));
  endtask

  task automatic t_random;
    logic [29:0] a, b;
    for (int i = 0; i < 40; i++) begin
      seed = nxt(seed); a = seed[29:0] >> seed[31:30];
      seed = nxt(seed); b = seed[29:0] >> seed[31:30];
      if (seed[7]) a = neg30(a);
      if (seed[9]) b = neg30(b);
      if (a == 30'h2000_0000) a = 30'h1FFF_FFFF;
      if (b == 30'h2000_0000) b = 30'h1FFF_FFFF;
      seed = nxt(seed);
      do_check(a, b, seed[1:0], "R3 R4 R5 random vector");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_signs;
    t_low;
    t_round;
    t_ovf;
    t_latency;
    t_busy;
    t_random;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule